// File: doc/BRIEF.md
# Quadrature Timer Channel with PWM Output

This block is one 16-bit timer channel controlled through a small register port. In its normal mode the counter advances by one on a selected count event. That event is either one of four prescaled tick strobes supplied from outside the block, or an edge of one of the two external pins. The edge polarity for the pins is selectable. In phase counting mode the two pins carry a quadrature signal, and the counter steps up or down on every valid transition of either pin. The source and edge selections have no effect in this mode.

Two general registers are compared against the counter at all times. A match with either register sets a status flag and can clear the counter, depending on the clear-select field. In PWM mode the two matches also drive the output pin: a match with register A sets it and a match with register B resets it. An overflow flag records a counter wrap. A programmable direction bit decides whether a wrap downwards also sets this flag. Every flag drives its own interrupt-request pin. Software clears a flag by writing 0 to that flag's bit.

Register map (3-bit address): 0 = control, 1 = mode, 2 = counter, 3 = general register A, 4 = general register B, 5 = status. Addresses 6 and 7 read as 0. Writes take effect at the clock edge where `bus_wr` is high. `bus_rdata` follows `bus_addr` combinationally. The block has no data stream, so every pin is a plain control or status signal and no valid/ready handshake is present.

Top module: `qtmr_channel`

## Requirements
- R1: After reset the counter reads 0x0000, both general registers read 0xFFFF, the control register reads 0, the mode register reads 0x0018, the status register reads 0, and `pwm_out` and all three interrupt pins are 0.
- R2: The mode register holds three bits: bit 0 enables phase counting, bit 1 enables PWM and bit 2 is the flag-direction bit. Bits 4 and 3 ignore writes and always read 1. All other bits read 0.
- R3: The control register holds the count source in bits 2:0, the edge select in bits 4:3 and the clear select in bits 6:5. In normal mode, source values 0 to 3 count cycles where `tick_in[source]` is high. Source 4 counts edges of `pin_a`, source 5 counts edges of `pin_b`, and sources 6 and 7 stop the counter. For the pin sources, edge select 0 counts rising edges, 1 counts falling edges, and 2 or 3 counts both.
- R4: In phase counting mode, the synchronized pin pair (A,B) moving through 00→10→11→01→00 steps the counter up by one per transition. The reverse order steps it down by one. A transition where both pins change together is ignored. The source and edge selections and `tick_in` have no effect, and the counter moves by at most one per clock.
- R5: A pin change is reflected in the counter no later than the third rising clock edge after it (two synchronizer stages, then the count update).
- R6: A step up from 0xFFFF gives 0x0000 and sets the overflow flag (status bit 2). A step down from 0x0000 gives 0xFFFF and sets the flag only when the flag-direction bit is 0. This rule holds in every mode.
- R7: While the counter equals general register A, status bit 0 is set. While it equals general register B, status bit 1 is set.
- R8: Clear select 1 clears the counter on a match with A, and clear select 2 clears it on a match with B. The counter reads 0 on the cycle after the match. Clear select 0 or 3 never clears the counter.
- R9: Writing 0 to a status bit clears that flag, and writing 1 leaves it unchanged. A hardware set in the same cycle as a software clear leaves the flag set.
- R10: With PWM enabled, `pwm_out` becomes 1 the cycle after a match with A and 0 the cycle after a match with B; B wins when both match. With PWM disabled, `pwm_out` holds its value.
- R11: `irq_cmpa`, `irq_cmpb` and `irq_ovf` always equal status bits 0, 1 and 2.
- R12: A software write to the counter takes priority over a clear and over a count step in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Register write data |
| bus_rdata | output | 16 | Register read data for `bus_addr` |
| tick_in | input | 4 | Prescaled tick strobes, one cycle each |
| pin_a | input | 1 | External clock / quadrature input A (asynchronous) |
| pin_b | input | 1 | External clock / quadrature input B (asynchronous) |
| pwm_out | output | 1 | Compare-driven output pin |
| irq_cmpa | output | 1 | Interrupt request, match with A |
| irq_cmpb | output | 1 | Interrupt request, match with B |
| irq_ovf | output | 1 | Interrupt request, overflow/underflow |

## Verification
Several rules are checked by assertions on every clock. These are the counter moving by at most one step, a clear or software write landing exactly on the following cycle, a wrap setting the overflow flag, a match setting its flag even when software clears it in the same cycle, and the PWM pin holding its value or falling after a B match. Other behaviour can only be shown by the bench's scenarios. This covers the up/down direction of each quadrature transition, the rejection of double-pin changes, the effect of the direction bit on underflow, the selection of source and edge in normal mode, and the read-back of the reserved mode bits.

// File: rtl/qtmr_pkg.sv
package qtmr_pkg;
  localparam int unsigned REG_AW   = 3;
  localparam int unsigned NUM_TICK = 4;
  localparam int unsigned TICK_SW  = $clog2(NUM_TICK);

  localparam logic [REG_AW-1:0] A_CTRL = 3'd0;
  localparam logic [REG_AW-1:0] A_MODE = 3'd1;
  localparam logic [REG_AW-1:0] A_CNT  = 3'd2;
  localparam logic [REG_AW-1:0] A_GRA  = 3'd3;
  localparam logic [REG_AW-1:0] A_GRB  = 3'd4;
  localparam logic [REG_AW-1:0] A_STAT = 3'd5;

  typedef enum logic [1:0] {
    CLR_OFF  = 2'd0,
    CLR_ON_A = 2'd1,
    CLR_ON_B = 2'd2,
    CLR_OFF2 = 2'd3
  } clr_sel_e;

  typedef enum logic [1:0] {
    EDG_RISE  = 2'd0,
    EDG_FALL  = 2'd1,
    EDG_BOTH  = 2'd2,
    EDG_BOTH2 = 2'd3
  } edge_sel_e;

  typedef struct packed {
    clr_sel_e  clr;
    edge_sel_e edg;
    logic [2:0] src;
  } ctrl_t;
endpackage

// File: rtl/qtmr_sync_edge.sv
module qtmr_sync_edge #(
  parameter int unsigned N      = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din,
  output logic [N-1:0] lvl,
  output logic [N-1:0] prev
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic [STAGES-1:0] sh;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sh      <= '0;
        prev[i] <= 1'b0;
      end else begin
        sh      <= {sh[STAGES-2:0], din[i]};
        prev[i] <= sh[STAGES-1];
      end
    end
    assign lvl[i] = sh[STAGES-1];
  end
endmodule

// File: rtl/qtmr_qdec.sv
module qtmr_qdec (
  input  logic [1:0] cur,   // {A,B}
  input  logic [1:0] old,   // {A,B} one cycle earlier
  output logic       up,
  output logic       dn
);
  function automatic logic fwd(input logic [1:0] f, input logic [1:0] t);
    return (f == 2'b00 && t == 2'b10) || (f == 2'b10 && t == 2'b11) ||
           (f == 2'b11 && t == 2'b01) || (f == 2'b01 && t == 2'b00);
  endfunction

  always_comb begin
    up = fwd(old, cur);
    dn = fwd(cur, old);
  end
endmodule

// File: rtl/qtmr_counter.sv
module qtmr_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_val,
  input  logic         clr,
  input  logic         inc,
  input  logic         dec,
  output logic [W-1:0] cnt,
  output logic         wrap_up,
  output logic         wrap_dn
);
  logic [W-1:0] nxt;

  always_comb begin
    nxt     = cnt;
    wrap_up = 1'b0;
    wrap_dn = 1'b0;
    if (wr_en) begin
      nxt = wr_val;
    end else if (clr) begin
      nxt = '0;
    end else if (inc) begin
      nxt     = cnt + 1'b1;
      wrap_up = &cnt;
    end else if (dec) begin
      nxt     = cnt - 1'b1;
      wrap_dn = ~|cnt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= nxt;
  end

  // R4
  one_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !clr) |=> (cnt == $past(cnt) || cnt == $past(cnt) + 1'b1 ||
                          cnt == $past(cnt) - 1'b1));
  // R8
  clear_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !wr_en) |=> (cnt == '0));
  // R12
  sw_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (cnt == $past(wr_val)));
endmodule

// File: rtl/qtmr_channel.sv
module qtmr_channel
  import qtmr_pkg::*;
#(
  parameter int unsigned CW = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic [REG_AW-1:0]   bus_addr,
  input  logic [CW-1:0]       bus_wdata,
  output logic [CW-1:0]       bus_rdata,
  input  logic [NUM_TICK-1:0] tick_in,
  input  logic                pin_a,
  input  logic                pin_b,
  output logic                pwm_out,
  output logic                irq_cmpa,
  output logic                irq_cmpb,
  output logic                irq_ovf
);
  localparam int unsigned CTRL_W = $bits(ctrl_t);

  ctrl_t        ctrl_q;
  logic         phase_q, pwm_en_q, fdir_q;
  logic [CW-1:0] gra_q, grb_q, cnt;
  logic         fl_a, fl_b, fl_ovf;
  logic [1:0]   s_lvl, s_prev, pin_evt;
  logic         q_up, q_dn, norm_evt, inc, dec, clr;
  logic         match_a, match_b, wrap_up, wrap_dn;
  logic         wr_ctrl, wr_mode, wr_cnt, wr_gra, wr_grb, wr_stat;

  assign wr_ctrl = bus_wr && bus_addr == A_CTRL;
  assign wr_mode = bus_wr && bus_addr == A_MODE;
  assign wr_cnt  = bus_wr && bus_addr == A_CNT;
  assign wr_gra  = bus_wr && bus_addr == A_GRA;
  assign wr_grb  = bus_wr && bus_addr == A_GRB;
  assign wr_stat = bus_wr && bus_addr == A_STAT;

  qtmr_sync_edge #(.N(2), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .din({pin_a, pin_b}), .lvl(s_lvl), .prev(s_prev)
  );

  qtmr_qdec u_qdec (.cur(s_lvl), .old(s_prev), .up(q_up), .dn(q_dn));

  // Per-pin edge event under the selected polarity (bit 1 = A, bit 0 = B)
  for (genvar p = 0; p < 2; p++) begin : g_pin
    always_comb begin
      unique case (ctrl_q.edg)
        EDG_RISE: pin_evt[p] = s_lvl[p] & ~s_prev[p];
        EDG_FALL: pin_evt[p] = ~s_lvl[p] & s_prev[p];
        default:  pin_evt[p] = s_lvl[p] ^ s_prev[p];
      endcase
    end
  end

  always_comb begin
    if (!ctrl_q.src[2])          norm_evt = tick_in[ctrl_q.src[TICK_SW-1:0]];
    else if (ctrl_q.src == 3'd4) norm_evt = pin_evt[1];
    else if (ctrl_q.src == 3'd5) norm_evt = pin_evt[0];
    else                         norm_evt = 1'b0;
  end

  assign inc     = phase_q ? q_up : norm_evt;
  assign dec     = phase_q & q_dn;
  assign match_a = (cnt == gra_q);
  assign match_b = (cnt == grb_q);
  assign clr     = (ctrl_q.clr == CLR_ON_A && match_a) ||
                   (ctrl_q.clr == CLR_ON_B && match_b);

  qtmr_counter #(.W(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_cnt), .wr_val(bus_wdata), .clr(clr),
    .inc(inc), .dec(dec), .cnt(cnt), .wrap_up(wrap_up), .wrap_dn(wrap_dn)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      phase_q  <= 1'b0;
      pwm_en_q <= 1'b0;
      fdir_q   <= 1'b0;
      gra_q    <= '1;
      grb_q    <= '1;
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
      if (wr_mode) {fdir_q, pwm_en_q, phase_q} <= bus_wdata[2:0];
      if (wr_gra)  gra_q <= bus_wdata;
      if (wr_grb)  grb_q <= bus_wdata;
    end
  end

  // Flags: hardware set beats software clear-by-zero
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fl_a   <= 1'b0;
      fl_b   <= 1'b0;
      fl_ovf <= 1'b0;
    end else begin
      fl_a   <= match_a | (fl_a & ~(wr_stat & ~bus_wdata[0]));
      fl_b   <= match_b | (fl_b & ~(wr_stat & ~bus_wdata[1]));
      fl_ovf <= wrap_up | (wrap_dn & ~fdir_q) |
                (fl_ovf & ~(wr_stat & ~bus_wdata[2]));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   pwm_out <= 1'b0;
    else if (pwm_en_q && match_b) pwm_out <= 1'b0;
    else if (pwm_en_q && match_a) pwm_out <= 1'b1;
  end

  assign irq_cmpa = fl_a;
  assign irq_cmpb = fl_b;
  assign irq_ovf  = fl_ovf;

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      A_CTRL:  bus_rdata[CTRL_W-1:0] = ctrl_q;
      A_MODE:  bus_rdata[4:0] = {2'b11, fdir_q, pwm_en_q, phase_q};
      A_CNT:   bus_rdata = cnt;
      A_GRA:   bus_rdata = gra_q;
      A_GRB:   bus_rdata = grb_q;
      A_STAT:  bus_rdata[2:0] = {fl_ovf, fl_b, fl_a};
      default: bus_rdata = '0;
    endcase
  end

  // R6
  ovf_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_up |=> irq_ovf);
  // R6
  udf_fdir0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_dn && !fdir_q) |=> irq_ovf);
  // R9
  hw_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match_a |=> irq_cmpa);
  // R10
  pwm_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_en_q && match_b) |=> !pwm_out);
  // R10
  pwm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwm_en_q |=> (pwm_out == $past(pwm_out)));
endmodule

// File: tb/qtmr_channel_tb.sv
module qtmr_channel_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = 3'd0;
  logic [15:0] bus_wdata = 16'd0;
  logic [15:0] bus_rdata;
  logic [3:0]  tick_in = 4'd0;
  logic        pin_a = 1'b0, pin_b = 1'b0;
  logic        pwm_out, irq_cmpa, irq_cmpb, irq_ovf;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  qtmr_channel u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_in(tick_in),
    .pin_a(pin_a), .pin_b(pin_b), .pwm_out(pwm_out), .irq_cmpa(irq_cmpa),
    .irq_cmpb(irq_cmpb), .irq_ovf(irq_ovf)
  );

  // Quadrature table: {A, B, expected overflow flag, expected count}
  localparam logic [18:0] QV [15] = '{
    {2'b10, 1'b0, 16'h0003}, {2'b11, 1'b0, 16'h0004}, {2'b01, 1'b0, 16'h0005},
    {2'b00, 1'b0, 16'h0006}, {2'b01, 1'b0, 16'h0005}, {2'b11, 1'b0, 16'h0004},
    {2'b10, 1'b0, 16'h0003}, {2'b00, 1'b0, 16'h0002}, {2'b11, 1'b0, 16'h0002},
    {2'b00, 1'b0, 16'h0002}, {2'b01, 1'b0, 16'h0001}, {2'b11, 1'b0, 16'h0000},
    {2'b10, 1'b1, 16'hFFFF}, {2'b11, 1'b1, 16'h0000}, {2'b01, 1'b1, 16'h0001}
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic pulse_tick(input logic [3:0] v, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_in = v;
      @(negedge clk); tick_in = 4'd0;
    end
  endtask

  task automatic pins(input logic a, input logic b);
    @(negedge clk);
    pin_a = a; pin_b = b;
    repeat (4) @(posedge clk);
  endtask

  task automatic finish_up();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_up();
    end
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    rd(3'd2, v); chk("R1 count", v, 16'h0000);
    rd(3'd3, v); chk("R1 gra", v, 16'hFFFF);
    rd(3'd4, v); chk("R1 grb", v, 16'hFFFF);
    rd(3'd0, v); chk("R1 ctrl", v, 16'h0000);
    rd(3'd1, v); chk("R1 mode", v, 16'h0018);
    rd(3'd5, v); chk("R1 status", v, 16'h0000);
    chk("R1 pins", {12'd0, pwm_out, irq_cmpa, irq_cmpb, irq_ovf}, 16'h0000);

    // R2 mode register, reserved bits
    wr(3'd1, 16'hFFFF); rd(3'd1, v); chk("R2 mode all ones", v, 16'h001F);
    wr(3'd1, 16'h0000); rd(3'd1, v); chk("R2 mode zero", v, 16'h0018);

    // R3 internal tick source 2; other strobes ignored
    wr(3'd0, 16'h0002);
    pulse_tick(4'b0110, 5);
    rd(3'd2, v); chk("R3 tick2 counts", v, 16'd5);
    pulse_tick(4'b1011, 3);
    rd(3'd2, v); chk("R3 other ticks ignored", v, 16'd5);
    // R3 pin A rising edges only
    wr(3'd0, 16'h0004);
    for (int i = 0; i < 3; i++) begin pins(1'b1, 1'b0); pins(1'b0, 1'b0); end
    rd(3'd2, v); chk("R3 pin_a rising", v, 16'd8);
    // R3 pin A falling edges only
    wr(3'd0, 16'h000C);
    pins(1'b1, 1'b0); rd(3'd2, v); chk("R3 rise not counted on falling select", v, 16'd8);
    pins(1'b0, 1'b0); rd(3'd2, v); chk("R3 pin_a falling", v, 16'd9);
    // R3 pin B both edges
    wr(3'd0, 16'h0015);
    for (int i = 0; i < 2; i++) begin pins(1'b0, 1'b1); pins(1'b0, 1'b0); end
    rd(3'd2, v); chk("R3 pin_b both edges", v, 16'd13);
    // R3 stopped source
    wr(3'd0, 16'h0006);
    pulse_tick(4'hF, 3); pins(1'b1, 1'b1); pins(1'b0, 1'b0);
    rd(3'd2, v); chk("R3 source 6 stopped", v, 16'd13);

    // R4/R5/R6 phase counting table, ticks held high to show override
    wr(3'd0, 16'h0000);
    wr(3'd1, 16'h0001);
    wr(3'd2, 16'h0002);
    wr(3'd5, 16'h0000);
    tick_in = 4'hF;
    for (int i = 0; i < 15; i++) begin
      pins(QV[i][18], QV[i][17]);
      rd(3'd2, v); chk($sformatf("R4 quad step %0d count", i), v, QV[i][15:0]);
      chk($sformatf("R6 quad step %0d ovf", i), {15'd0, irq_ovf}, {15'd0, QV[i][16]});
    end
    tick_in = 4'h0;

    // R6 flag direction = 1: underflow does not set the flag
    wr(3'd1, 16'h0005);
    wr(3'd2, 16'h0000);
    wr(3'd5, 16'h0000);
    pins(1'b1, 1'b1);
    rd(3'd2, v); chk("R6 underflow count", v, 16'hFFFF);
    rd(3'd5, v); chk("R6 underflow no flag when direction=1", {15'd0, v[2]}, 16'd0);
    pins(1'b0, 1'b1);
    rd(3'd2, v); chk("R6 overflow count", v, 16'h0000);
    chk("R6 overflow sets flag when direction=1", {15'd0, irq_ovf}, 16'd1);

    // R7/R8/R10/R11 compare, clear on B, PWM
    wr(3'd1, 16'h0002);
    wr(3'd0, 16'h0040);
    wr(3'd3, 16'd3);
    wr(3'd4, 16'd6);
    wr(3'd2, 16'd0);
    wr(3'd5, 16'h0000);
    pulse_tick(4'b0001, 3);
    repeat (2) @(posedge clk);
    rd(3'd5, v); chk("R7 match A flag", v, 16'h0001);
    chk("R11 irq_cmpa", {15'd0, irq_cmpa}, 16'd1);
    chk("R10 pwm high after A", {15'd0, pwm_out}, 16'd1);
    pulse_tick(4'b0001, 3);
    repeat (2) @(posedge clk);
    rd(3'd2, v); chk("R8 cleared on B", v, 16'd0);
    chk("R10 pwm low after B", {15'd0, pwm_out}, 16'd0);
    chk("R11 irq_cmpb", {15'd0, irq_cmpb}, 16'd1);

    // R9 flag clearing
    wr(3'd5, 16'h0000); rd(3'd5, v); chk("R9 write zero clears", v, 16'h0000);
    wr(3'd5, 16'h0007); rd(3'd5, v); chk("R9 write one no effect", v, 16'h0000);
    wr(3'd2, 16'd3);
    wr(3'd5, 16'h0000); rd(3'd5, v); chk("R9 hw set beats clear", {15'd0, v[0]}, 16'd1);

    // R10 hold with PWM disabled (output currently 1)
    wr(3'd1, 16'h0000);
    wr(3'd2, 16'd6);
    repeat (2) @(posedge clk);
    rd(3'd2, v); chk("R8 clear on B without PWM", v, 16'd0);
    chk("R10 pwm holds when disabled", {15'd0, pwm_out}, 16'd1);

    // R10 both registers match: B wins
    wr(3'd0, 16'h0000);
    wr(3'd1, 16'h0002);
    wr(3'd3, 16'd9);
    wr(3'd4, 16'd9);
    wr(3'd2, 16'd9);
    repeat (2) @(posedge clk);
    #1 chk("R10 B wins on tie", {15'd0, pwm_out}, 16'd0);

    // R8 clear on A, and no clear with select 0
    wr(3'd3, 16'd3);
    wr(3'd0, 16'h0020);
    wr(3'd2, 16'd3);
    rd(3'd2, v); chk("R8 clear on A", v, 16'd0);
    wr(3'd0, 16'h0000);
    wr(3'd2, 16'd3);
    repeat (2) @(posedge clk);
    rd(3'd2, v); chk("R8 no clear with select 0", v, 16'd3);

    // R12 software write beats a count step
    @(negedge clk) tick_in = 4'b0001;
    wr(3'd2, 16'h0100);
    tick_in = 4'b0000;
    rd(3'd2, v); chk("R12 write priority", v, 16'h0100);

    done = 1'b1;
    finish_up();
  end
endmodule